// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit integer execution unit for short-vector media code. Each operand is split into equal lanes of 8, 16 or 32 bits, and one operation is applied to all lanes at once, with no carry or shifted bit passing from one lane into the next. Add and subtract can wrap or clamp to the signed or unsigned range of the lane. The logic, shift and compare operations work lane by lane, and two reshaping operations narrow or interleave lanes.

A request is one `in_valid` cycle carrying the operation, the lane width, the saturation mode and the two operands. The result is registered and appears with `out_valid` on the following cycle. There is no backpressure: a new request can be presented on every cycle. The output stage has two conditions. It is idle after reset and on any cycle without a request, and it holds its last result. It is loaded on the edge that follows a request cycle, which sets `out_valid` for one cycle.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_data` are cleared to 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_data` keeps its previous value regardless of the other inputs.
- R3: `lane_sel` 0, 1 and 2 select 8-, 16- and 32-bit lanes. With `sat_sel` 0 or 3, add (`op_sel` 0) and subtract (`op_sel` 1) wrap modulo the lane size, and no carry or borrow crosses a lane boundary.
- R4: With `sat_sel` 1, add and subtract treat lanes as two's complement, and a result outside the range is clamped to the lane's most positive or most negative value.
- R5: With `sat_sel` 2, add and subtract treat lanes as unsigned. A carry out clamps the lane to all ones and a borrow clamps it to zero.
- R6: `op_sel` 2 gives A and B, 3 gives (not A) and B, 4 gives A or B, and 5 gives A xor B.
- R7: `op_sel` 6, 7 and 8 shift every lane of A left logically, right logically, or right arithmetically by the unsigned count in B bits 7:0. If the count is at least the lane width, the result is 0 for the logical shifts and a copy of the lane's sign bit for the arithmetic shift.
- R8: `op_sel` 9 (equal) and 10 (A greater than B, as signed values) set every bit of a lane to 1 when the test holds and to 0 when it does not.
- R9: `op_sel` 11 narrows each lane to half its width. Lane `lane_sel` 1 narrows 16-bit lanes to 8 bits and `lane_sel` 2 narrows 32-bit lanes to 16 bits. The narrowed lanes of A fill the low half of the result and those of B fill the high half, each in lane order. Sources are signed. Values that do not fit are clamped to the signed range, or to 0 and all ones when `sat_sel` is 2. With 8-bit lanes the result is 0.
- R10: `op_sel` 12 interleaves the low half of the lanes of A and B. Result lane 2k is lane k of A and result lane 2k+1 is lane k of B.
- R11: `lane_sel` 3 acts as 32-bit lanes, and `op_sel` 13 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 4 | Operation code |
| lane_sel | input | 2 | Lane width code |
| sat_sel | input | 2 | Saturation mode for add/subtract and pack |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B, and the shift count in bits 7:0 |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Registered result |

## Verification
Every result is due on the rising edge after the request cycle: one register lies between the operands and `out_data`. The bench drives each request on a falling edge and compares `out_data` and `out_valid` on the next falling edge, half a period after the register has loaded. The hold behaviour is checked one falling edge after `in_valid` drops, while the operands are being changed. The sweeps cover every operation, lane code and saturation code, using boundary lane patterns and pseudo-random operands. Shift counts run past the widest lane.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_ANDN = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_CEQ  = 4'd9,
        OP_CGT  = 4'd10,
        OP_PACK = 4'd11,
        OP_UNPK = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        SAT_WRAP = 2'd0,
        SAT_SGN  = 2'd1,
        SAT_USG  = 2'd2,
        SAT_ALT  = 2'd3
    } sat_e;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    input  sat_e         sat,
    input  logic [7:0]   shamt,
    output logic [W-1:0] y
);
    localparam int SW = $clog2(W);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] u_sum, u_dif, s_sum, s_dif;
    logic       big;
    logic [SW-1:0] sh;

    assign u_sum = {1'b0, a} + {1'b0, b};
    assign u_dif = {1'b0, a} - {1'b0, b};
    assign s_sum = {a[W-1], a} + {b[W-1], b};
    assign s_dif = {a[W-1], a} - {b[W-1], b};
    assign big   = (int'(shamt) >= W);
    assign sh    = shamt[SW-1:0];

    always_comb begin
        case (op)
            OP_ADD: begin
                if (sat == SAT_SGN)
                    y = (s_sum[W] != s_sum[W-1]) ? (s_sum[W] ? SMIN : SMAX) : s_sum[W-1:0];
                else if (sat == SAT_USG)
                    y = u_sum[W] ? '1 : u_sum[W-1:0];
                else
                    y = u_sum[W-1:0];
            end
            OP_SUB: begin
                if (sat == SAT_SGN)
                    y = (s_dif[W] != s_dif[W-1]) ? (s_dif[W] ? SMIN : SMAX) : s_dif[W-1:0];
                else if (sat == SAT_USG)
                    y = u_dif[W] ? '0 : u_dif[W-1:0];
                else
                    y = u_dif[W-1:0];
            end
            OP_AND:  y = a & b;
            OP_ANDN: y = ~a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLL:  y = big ? '0 : (a << sh);
            OP_SRL:  y = big ? '0 : (a >> sh);
            OP_SRA:  y = big ? {W{a[W-1]}} : W'($signed(a) >>> sh);
            OP_CEQ:  y = {W{a == b}};
            OP_CGT:  y = {W{$signed(a) > $signed(b)}};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/simd_narrow.sv
module simd_narrow #(
    parameter int IW = 16
) (
    input  logic [IW-1:0]   v,
    input  logic            uns,
    output logic [IW/2-1:0] y
);
    localparam int OW = IW / 2;

    always_comb begin
        if (uns) begin
            if (v[IW-1])
                y = '0;
            else if (|v[IW-2:OW])
                y = '1;
            else
                y = v[OW-1:0];
        end else begin
            if ((&v[IW-1:OW-1]) || !(|v[IW-1:OW-1]))
                y = v[OW-1:0];
            else
                y = v[IW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
        end
    end
endmodule

// File: rtl/simd_reshape.sv
module simd_reshape #(
    parameter int DW   = 64,
    parameter int BASE = 8,
    parameter int NW   = 3
) (
    input  logic [DW-1:0]          a,
    input  logic [DW-1:0]          b,
    input  logic                   uns,
    output logic [NW-1:0][DW-1:0]  pack_y,
    output logic [NW-1:0][DW-1:0]  unpk_y
);
    for (genvar g = 0; g < NW; g++) begin : g_w
        localparam int LW = BASE << g;
        localparam int LN = DW / LW;
        localparam int HW = LW / 2;

        for (genvar k = 0; k < LN / 2; k++) begin : g_unpk
            assign unpk_y[g][(2*k)*LW +: LW]   = a[k*LW +: LW];
            assign unpk_y[g][(2*k+1)*LW +: LW] = b[k*LW +: LW];
        end

        if (g == 0) begin : g_nopack
            assign pack_y[g] = '0;
        end else begin : g_pack
            for (genvar k = 0; k < LN; k++) begin : g_lane
                simd_narrow #(.IW(LW)) u_na (
                    .v(a[k*LW +: LW]), .uns(uns), .y(pack_y[g][k*HW +: HW]));
                simd_narrow #(.IW(LW)) u_nb (
                    .v(b[k*LW +: LW]), .uns(uns), .y(pack_y[g][(LN+k)*HW +: HW]));
            end
        end
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DW   = 64,
    parameter int BASE = 8,
    parameter int NW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op_sel,
    input  logic [1:0]    lane_sel,
    input  logic [1:0]    sat_sel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam int NB = DW / 8;

    op_e  op_w;
    sat_e sat_w;
    logic [1:0] widx;
    logic [NW-1:0][DW-1:0] lane_y, pack_y, unpk_y;
    logic [DW-1:0] res_d;

    assign op_w  = op_e'(op_sel);
    assign sat_w = sat_e'(sat_sel);
    assign widx  = (lane_sel == 2'd0) ? 2'd0 : (lane_sel == 2'd1) ? 2'd1 : 2'd2;

    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int LW = BASE << g;
        localparam int LN = DW / LW;
        for (genvar k = 0; k < LN; k++) begin : g_lane
            simd_lane #(.W(LW)) u_lane (
                .a(opa[k*LW +: LW]), .b(opb[k*LW +: LW]),
                .op(op_w), .sat(sat_w), .shamt(opb[7:0]),
                .y(lane_y[g][k*LW +: LW]));
        end
    end

    simd_reshape #(.DW(DW), .BASE(BASE), .NW(NW)) u_reshape (
        .a(opa), .b(opb), .uns(sat_w == SAT_USG),
        .pack_y(pack_y), .unpk_y(unpk_y));

    always_comb begin
        unique case (op_w)
            OP_PACK: res_d = pack_y[widx];
            OP_UNPK: res_d = unpk_y[widx];
            OP_ADD, OP_SUB, OP_AND, OP_ANDN, OP_OR, OP_XOR,
            OP_SLL, OP_SRL, OP_SRA, OP_CEQ, OP_CGT:
                     res_d = lane_y[widx];
            default: res_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= res_d;
        end
    end

    function automatic logic masks_ok(input logic [DW-1:0] r);
        logic ok = 1'b1;
        for (int i = 0; i < NB; i++)
            if (r[i*8 +: 8] != 8'h00 && r[i*8 +: 8] != 8'hFF) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic bytes_ge(input logic [DW-1:0] r, input logic [DW-1:0] x);
        logic ok = 1'b1;
        for (int i = 0; i < NB; i++)
            if (r[i*8 +: 8] < x[i*8 +: 8]) ok = 1'b0;
        return ok;
    endfunction

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));
    assert_usat_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_ADD && sat_sel == SAT_USG && lane_sel == 2'd0)
        |=> bytes_ge(out_data, $past(opa)));
    assert_and_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_AND) |=> ((out_data & ~$past(opa)) == '0));
    assert_cmp_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == OP_CEQ || op_sel == OP_CGT)) |=> masks_ok(out_data));
    assert_bad_op_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel > 4'd12) |=> (out_data == '0));
endmodule

// File: tb/simd_alu_bench.sv
module simd_alu_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [1:0]  lane_sel = '0;
    logic [1:0]  sat_sel = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    simd_alu u_simd_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .lane_sel(lane_sel), .sat_sel(sat_sel), .opa(opa), .opb(opb),
        .out_valid(out_valid), .out_data(out_data));

    function automatic longint clampl(longint v, longint lo, longint hi);
        return (v < lo) ? lo : (v > hi) ? hi : v;
    endfunction

    function automatic logic [63:0] model(int op, int ws, int sat, logic [63:0] a, logic [63:0] b);
        int w = (ws == 0) ? 8 : (ws == 1) ? 16 : 32;
        int ln = 64 / w;
        longint lim = longint'(1) << w;
        longint msk = lim - 1;
        int s = int'(b[7:0]);
        logic [63:0] res = '0;
        if (op == 11) begin
            if (w == 8) return '0;
            for (int k = 0; k < ln; k++) begin
                int nw = w / 2;
                longint nl = longint'(1) << nw;
                longint ua = longint'(a >> (k*w)) & msk;
                longint ub = longint'(b >> (k*w)) & msk;
                longint sa = (ua >= lim/2) ? ua - lim : ua;
                longint sb = (ub >= lim/2) ? ub - lim : ub;
                longint ra = (sat == 2) ? clampl(sa, 0, nl-1) : clampl(sa, -nl/2, nl/2-1);
                longint rb = (sat == 2) ? clampl(sb, 0, nl-1) : clampl(sb, -nl/2, nl/2-1);
                res |= 64'(ra & (nl-1)) << (k*nw);
                res |= 64'(rb & (nl-1)) << ((ln+k)*nw);
            end
            return res;
        end
        if (op == 12) begin
            for (int k = 0; k < ln/2; k++) begin
                res |= 64'(longint'(a >> (k*w)) & msk) << (2*k*w);
                res |= 64'(longint'(b >> (k*w)) & msk) << ((2*k+1)*w);
            end
            return res;
        end
        if (op > 12) return '0;
        for (int k = 0; k < ln; k++) begin
            longint ua = longint'(a >> (k*w)) & msk;
            longint ub = longint'(b >> (k*w)) & msk;
            longint sa = (ua >= lim/2) ? ua - lim : ua;
            longint sb = (ub >= lim/2) ? ub - lim : ub;
            longint r = 0;
            case (op)
                0: r = (sat == 1) ? clampl(sa+sb, -lim/2, lim/2-1) :
                       (sat == 2) ? clampl(ua+ub, 0, lim-1) : ua+ub;
                1: r = (sat == 1) ? clampl(sa-sb, -lim/2, lim/2-1) :
                       (sat == 2) ? clampl(ua-ub, 0, lim-1) : ua-ub;
                2: r = ua & ub;
                3: r = ~ua & ub;
                4: r = ua | ub;
                5: r = ua ^ ub;
                6: r = (s >= w) ? 0 : (ua << s);
                7: r = (s >= w) ? 0 : (ua >> s);
                8: r = (s >= w) ? ((sa < 0) ? -1 : 0) : (sa >>> s);
                9: r = (ua == ub) ? -1 : 0;
                10: r = (sa > sb) ? -1 : 0;
                default: r = 0;
            endcase
            res |= 64'(r & msk) << (k*w);
        end
        return res;
    endfunction

    function automatic string tag_of(int op, int ws, int sat);
        if (op > 12 || ws == 3) return "R11";
        if (op <= 1) return (sat == 1) ? "R4" : (sat == 2) ? "R5" : "R3";
        if (op <= 5) return "R6";
        if (op <= 8) return "R7";
        if (op <= 10) return "R8";
        if (op == 11) return "R9";
        return "R10";
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Called on a falling edge; checks on the next falling edge.
    task automatic issue(int op, int ws, int sat, logic [63:0] a, logic [63:0] b);
        in_valid = 1'b1;
        op_sel = 4'(op); lane_sel = 2'(ws); sat_sel = 2'(sat);
        opa = a; opb = b;
        @(negedge clk);
        check("R2", {63'b0, out_valid}, 64'd1);
        check(tag_of(op, ws, sat), out_data, model(op, ws, sat, a, b));
    endtask

    logic [63:0] pats [6];
    logic [63:0] last;

    initial begin
        pats[0] = 64'h0000_0000_0000_0000;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h7F7F_7F7F_7FFF_7FFF;
        pats[3] = 64'h8080_8080_8000_8000;
        pats[4] = 64'h7FFF_FFFF_8000_0000;
        pats[5] = 64'h0180_7F01_FF00_80FE;

        in_valid = 1'b1;
        opa = pats[5];
        repeat (3) @(negedge clk);
        // R1: reset clears the output stage even with a request present
        check("R1", {63'b0, out_valid}, 64'd0);
        check("R1", out_data, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", {63'b0, out_valid}, 64'd0);

        for (int op = 0; op < 16; op++)
            for (int ws = 0; ws < 4; ws++)
                for (int sat = 0; sat < 4; sat++) begin
                    for (int i = 0; i < 6; i++)
                        for (int j = 0; j < 6; j++)
                            issue(op, ws, sat, pats[i], pats[j]);
                    for (int v = 0; v < 30; v++) begin
                        logic [63:0] ra = {$urandom, $urandom};
                        logic [63:0] rb = {$urandom, $urandom};
                        if (op >= 6 && op <= 8) rb[7:0] = 8'(v * 2);
                        issue(op, ws, sat, ra, rb);
                    end
                end

        // R2: idle cycles hold the last result while inputs change
        last = out_data;
        in_valid = 1'b0;
        opa = ~opa; opb = ~opb; op_sel = 4'd5;
        @(negedge clk);
        check("R2", {63'b0, out_valid}, 64'd0);
        check("R2", out_data, last);
        opa = 64'h1234; op_sel = 4'd0;
        @(negedge clk);
        check("R2", out_data, last);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule